// File: doc/BRIEF.md
# Duplicate-Result Checker with Reference Register File

This block sits beside one functional unit of a wide-issue datapath in which every operation is issued twice, on two different units, and possibly in two different cycles. The first copy of a pair deposits its result as a reference value in a small temporary register file. The second copy reads that reference back and compares it with its own result. Because the reference stays stored until it is overwritten, the two copies of an operation may be scheduled any number of cycles apart.

Each issued slot brings the unit's result and opcode, together with three instruction-word fields: a check-mode bit (0 = store reference, 1 = compare), a reference-slot index and the number of the partner unit. A second write port lets a partner unit deposit references into the same temporary file. The checker also holds one fault bit per operator (indexed by opcode). The voting controller sets these bits through an update strobe. A compare that mismatches is reported one cycle later, either as a new error or as a mismatch on an operator already flagged. A new-error report carries the failing opcode and the partner unit number so that the voting controller can tell which pair of units disagreed.

The report logic is a four-state machine whose state is the outcome of the previous cycle: `RPT_IDLE` (nothing to report), `RPT_MATCH` (compare agreed), `RPT_NEW` (first-time mismatch) and `RPT_KNOWN` (mismatch on a flagged operator). Every state can move to every other state in any cycle. The transitions are: *quiet* (no valid compare, so the next state is `RPT_IDLE`), *agree* (valid compare whose values are equal, so `RPT_MATCH`), *first_fault* (unequal values, operator bit clear, so `RPT_NEW`) and *repeat_fault* (unequal values, operator bit set, so `RPT_KNOWN`).

Top module: `dup_result_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fault_vec` is all zero and `cmp_ok`, `err_new` and `err_known` are low. Every reference slot reads as zero until it is written.
- R2: A valid slot with `chk_mode`=0 writes `op_result` into reference slot `ref_idx` at the clock edge. In the following cycle it produces no report: `cmp_ok`, `err_new` and `err_known` are all low.
- R3: A valid slot with `chk_mode`=1 whose `op_result` equals the value in slot `ref_idx` raises `cmp_ok` for exactly the one cycle after the edge, with `err_new` and `err_known` low.
- R4: A valid slot with `chk_mode`=1 whose result differs from the reference, while `fault_vec[op_code]` is 0, raises `err_new` for the one cycle after the edge. In that cycle `err_opcode` equals `op_code` and `err_unit` equals `ref_unit`.
- R5: A mismatching compare while `fault_vec[op_code]` is 1 raises `err_known` (with `err_opcode`/`err_unit` as in R4) and leaves `err_new` low.
- R6: A reference persists for any number of cycles until its own slot is written again. Writes to other slots and compares do not change it.
- R7: The partner write port (`peer_we`, `peer_idx`, `peer_data`) writes a reference slot. A compare in the same cycle on the same slot sees the newly written value.
- R8: When an own store (valid, mode 0) and a partner write target the same slot in the same cycle, the own value is kept.
- R9: `fault_set` sets bit `fault_set_op` of `fault_vec`, visible the cycle after the edge. Bits are never cleared except by reset. A compare in the same cycle as the strobe is classified against the vector before the update.
- R10: With `op_valid` low, the slot fields are ignored: no reference is written and no report follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | The unit issued an operation this cycle |
| op_code | input | OPC_W | Opcode; also the operator index into `fault_vec` |
| op_result | input | DATA_W | Result produced by the unit |
| chk_mode | input | 1 | 0 = store reference, 1 = compare with reference |
| ref_idx | input | REF_IDX_W | Reference slot index |
| ref_unit | input | UNIT_W | Number of the unit running the partner copy |
| peer_we | input | 1 | Partner unit writes a reference |
| peer_idx | input | REF_IDX_W | Slot written by the partner |
| peer_data | input | DATA_W | Value written by the partner |
| fault_set | input | 1 | Voting-controller strobe marking an operator faulty |
| fault_set_op | input | OPC_W | Operator to mark |
| cmp_ok | output | 1 | Previous-cycle compare agreed |
| err_new | output | 1 | Previous-cycle compare hit a first-time fault |
| err_known | output | 1 | Previous-cycle compare hit a flagged operator |
| err_opcode | output | OPC_W | Opcode of the reported compare |
| err_unit | output | UNIT_W | Partner unit of the reported compare |
| fault_vec | output | 2**OPC_W | One bit per operator, 1 = known faulty |

## Verification
The bench goes after pairs that are split by several idle and unrelated cycles. A file that lost or overwrote references would turn these into false errors. It drives a fault strobe in the same cycle as a mismatch on the same operator: a design that classified against the updated vector would report known instead of new. It also covers a partner write and a compare to one slot in one cycle, which would fail without the bypass, and colliding own and partner writes, where the wrong priority shows up as a mismatch on the later compare. Finally it drives stores and mismatching compares with `op_valid` low: a design that honoured them would corrupt a slot or raise a spurious report.

// File: rtl/dup_chk_pkg.sv
package dup_chk_pkg;

    // Outcome of the previous cycle, held as the report state.
    typedef enum logic [1:0] {
        RPT_IDLE  = 2'd0,
        RPT_MATCH = 2'd1,
        RPT_NEW   = 2'd2,
        RPT_KNOWN = 2'd3
    } report_state_e;

endpackage

// File: rtl/ref_regfile.sv
module ref_regfile #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_we,
    input  logic [IDX_W-1:0]  own_idx,
    input  logic [DATA_W-1:0] own_data,
    input  logic              peer_we,
    input  logic [IDX_W-1:0]  peer_idx,
    input  logic [DATA_W-1:0] peer_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    // One register per slot; the own port wins over the partner port.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic own_hit;
        logic peer_hit;
        assign own_hit  = own_we  && (own_idx  == IDX_W'(s));
        assign peer_hit = peer_we && (peer_idx == IDX_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (own_hit) begin
                slot_q[s] <= own_data;
            end else if (peer_hit) begin
                slot_q[s] <= peer_data;
            end
        end
    end

    // Combinational read with a bypass of a same-cycle partner write.
    always_comb begin
        if (peer_we && (peer_idx == rd_idx)) begin
            rd_data = peer_data;
        end else begin
            rd_data = slot_q[rd_idx];
        end
    end

endmodule

// File: rtl/fault_vector.sv
module fault_vector #(
    parameter int OPC_W = 4,
    localparam int NUM_OPS = 1 << OPC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [OPC_W-1:0]   set_op,
    output logic [NUM_OPS-1:0] vec
);

    for (genvar b = 0; b < NUM_OPS; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vec[b] <= 1'b0;
            end else if (set_en && (set_op == OPC_W'(b))) begin
                vec[b] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/result_classifier.sv
module result_classifier
    import dup_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              op_valid,
    input  logic              chk_mode,
    input  logic [DATA_W-1:0] op_result,
    input  logic [DATA_W-1:0] ref_value,
    input  logic              op_flagged,
    output report_state_e     outcome
);

    logic do_compare;
    logic values_differ;

    assign do_compare    = op_valid && chk_mode;
    assign values_differ = (op_result != ref_value);

    always_comb begin
        if (!do_compare) begin
            outcome = RPT_IDLE;          // quiet
        end else if (!values_differ) begin
            outcome = RPT_MATCH;         // agree
        end else if (!op_flagged) begin
            outcome = RPT_NEW;           // first_fault
        end else begin
            outcome = RPT_KNOWN;         // repeat_fault
        end
    end

endmodule

// File: rtl/dup_result_checker.sv
module dup_result_checker
    import dup_chk_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int OPC_W     = 4,
    parameter int REF_DEPTH = 8,
    parameter int UNIT_W    = 3,
    localparam int REF_IDX_W = $clog2(REF_DEPTH),
    localparam int NUM_OPS   = 1 << OPC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [OPC_W-1:0]     op_code,
    input  logic [DATA_W-1:0]    op_result,
    input  logic                 chk_mode,
    input  logic [REF_IDX_W-1:0] ref_idx,
    input  logic [UNIT_W-1:0]    ref_unit,
    input  logic                 peer_we,
    input  logic [REF_IDX_W-1:0] peer_idx,
    input  logic [DATA_W-1:0]    peer_data,
    input  logic                 fault_set,
    input  logic [OPC_W-1:0]     fault_set_op,
    output logic                 cmp_ok,
    output logic                 err_new,
    output logic                 err_known,
    output logic [OPC_W-1:0]     err_opcode,
    output logic [UNIT_W-1:0]    err_unit,
    output logic [NUM_OPS-1:0]   fault_vec
);

    report_state_e     state_q;
    report_state_e     state_d;
    logic [DATA_W-1:0] ref_value;
    logic              own_store;

    assign own_store = op_valid && !chk_mode;

    ref_regfile #(
        .DATA_W (DATA_W),
        .DEPTH  (REF_DEPTH)
    ) u_refs (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_we    (own_store),
        .own_idx   (ref_idx),
        .own_data  (op_result),
        .peer_we   (peer_we),
        .peer_idx  (peer_idx),
        .peer_data (peer_data),
        .rd_idx    (ref_idx),
        .rd_data   (ref_value)
    );

    fault_vector #(
        .OPC_W (OPC_W)
    ) u_faults (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (fault_set),
        .set_op (fault_set_op),
        .vec    (fault_vec)
    );

    result_classifier #(
        .DATA_W (DATA_W)
    ) u_classify (
        .op_valid   (op_valid),
        .chk_mode   (chk_mode),
        .op_result  (op_result),
        .ref_value  (ref_value),
        .op_flagged (fault_vec[op_code]),
        .outcome    (state_d)
    );

    // State register, with the report tag fields captured alongside.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= RPT_IDLE;
            err_opcode <= '0;
            err_unit   <= '0;
        end else begin
            state_q <= state_d;
            if (op_valid && chk_mode) begin
                err_opcode <= op_code;
                err_unit   <= ref_unit;
            end
        end
    end

    // Output decode of the report state.
    always_comb begin
        cmp_ok    = 1'b0;
        err_new   = 1'b0;
        err_known = 1'b0;
        unique case (state_q)
            RPT_IDLE:  ;
            RPT_MATCH: cmp_ok    = 1'b1;
            RPT_NEW:   err_new   = 1'b1;
            RPT_KNOWN: err_known = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/dup_result_checker_sva.sv
module dup_result_checker_sva #(
    parameter int DATA_W    = 32,
    parameter int OPC_W     = 4,
    parameter int REF_DEPTH = 8,
    parameter int UNIT_W    = 3,
    localparam int REF_IDX_W = $clog2(REF_DEPTH),
    localparam int NUM_OPS   = 1 << OPC_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic [OPC_W-1:0]     op_code,
    input logic                 chk_mode,
    input logic [UNIT_W-1:0]    ref_unit,
    input logic                 fault_set,
    input logic                 cmp_ok,
    input logic                 err_new,
    input logic                 err_known,
    input logic [OPC_W-1:0]     err_opcode,
    input logic [UNIT_W-1:0]    err_unit,
    input logic [NUM_OPS-1:0]   fault_vec
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3
    one_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmp_ok, err_new, err_known}));

    // R2
    store_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_valid && !chk_mode) |-> !(cmp_ok || err_new || err_known));

    // R10
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(op_valid) |-> !(cmp_ok || err_new || err_known));

    // R4
    new_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && err_new |-> (err_opcode == $past(op_code)) && (err_unit == $past(ref_unit))
            && ((($past(fault_vec) >> err_opcode) & NUM_OPS'(1)) == '0));

    // R5
    known_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && err_known |-> ((($past(fault_vec) >> err_opcode) & NUM_OPS'(1)) != '0));

    // R9
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(fault_vec) & ~fault_vec) == '0));

    // R9
    strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (fault_vec != $past(fault_vec)) |-> $past(fault_set));

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_clear_chk: assert (fault_vec == '0);
        end
    end

endmodule

bind dup_result_checker dup_result_checker_sva #(
    .DATA_W    (DATA_W),
    .OPC_W     (OPC_W),
    .REF_DEPTH (REF_DEPTH),
    .UNIT_W    (UNIT_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .chk_mode   (chk_mode),
    .ref_unit   (ref_unit),
    .fault_set  (fault_set),
    .cmp_ok     (cmp_ok),
    .err_new    (err_new),
    .err_known  (err_known),
    .err_opcode (err_opcode),
    .err_unit   (err_unit),
    .fault_vec  (fault_vec)
);

// File: tb/dup_result_checker_test.sv
`timescale 1ns/1ps
module dup_result_checker_test;

    localparam int DATA_W = 32;
    localparam int OPC_W  = 4;
    localparam int DEPTH  = 8;
    localparam int UNIT_W = 3;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int NOPS   = 1 << OPC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [OPC_W-1:0]  op_code = '0;
    logic [DATA_W-1:0] op_result = '0;
    logic              chk_mode = 1'b0;
    logic [IDX_W-1:0]  ref_idx = '0;
    logic [UNIT_W-1:0] ref_unit = '0;
    logic              peer_we = 1'b0;
    logic [IDX_W-1:0]  peer_idx = '0;
    logic [DATA_W-1:0] peer_data = '0;
    logic              fault_set = 1'b0;
    logic [OPC_W-1:0]  fault_set_op = '0;
    logic              cmp_ok, err_new, err_known;
    logic [OPC_W-1:0]  err_opcode;
    logic [UNIT_W-1:0] err_unit;
    logic [NOPS-1:0]   fault_vec;

    always #4 clk = ~clk;   // 125 MHz

    dup_result_checker #(
        .DATA_W(DATA_W), .OPC_W(OPC_W), .REF_DEPTH(DEPTH), .UNIT_W(UNIT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_result(op_result), .chk_mode(chk_mode), .ref_idx(ref_idx),
        .ref_unit(ref_unit), .peer_we(peer_we), .peer_idx(peer_idx),
        .peer_data(peer_data), .fault_set(fault_set), .fault_set_op(fault_set_op),
        .cmp_ok(cmp_ok), .err_new(err_new), .err_known(err_known),
        .err_opcode(err_opcode), .err_unit(err_unit), .fault_vec(fault_vec)
    );

    typedef struct {
        logic              ok;
        logic              nw;
        logic              kn;
        logic [OPC_W-1:0]  opc;
        logic [UNIT_W-1:0] unit;
        logic [NOPS-1:0]   fv;
        string             tag;
    } expect_t;

    expect_t           sb_q[$];
    logic [DATA_W-1:0] model_ref [DEPTH];
    logic [NOPS-1:0]   model_fv;
    int                checks = 0;
    int                fails  = 0;
    bit                done   = 0;

    // Driver: applies one slot at a negative edge and queues what must follow.
    task automatic drive(input logic v, input logic [OPC_W-1:0] opc,
                         input logic [DATA_W-1:0] res, input logic mode,
                         input logic [IDX_W-1:0] idx, input logic [UNIT_W-1:0] unit,
                         input logic fs, input logic [OPC_W-1:0] fsop,
                         input logic pw, input logic [IDX_W-1:0] pidx,
                         input logic [DATA_W-1:0] pdata, input string tag);
        expect_t e;
        logic [DATA_W-1:0] refv;
        @(negedge clk);
        op_valid = v; op_code = opc; op_result = res; chk_mode = mode;
        ref_idx = idx; ref_unit = unit; fault_set = fs; fault_set_op = fsop;
        peer_we = pw; peer_idx = pidx; peer_data = pdata;
        e.ok = 0; e.nw = 0; e.kn = 0; e.opc = opc; e.unit = unit; e.tag = tag;
        if (v && mode) begin
            refv = (pw && pidx == idx) ? pdata : model_ref[idx];
            if (refv == res)       e.ok = 1;
            else if (model_fv[opc]) e.kn = 1;
            else                   e.nw = 1;
        end
        if (pw) model_ref[pidx] = pdata;
        if (v && !mode) model_ref[idx] = res;
        if (fs) model_fv[fsop] = 1'b1;
        e.fv = model_fv;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(0, '0, '0, 0, '0, '0, 0, '0, 0, '0, '0, tag);
    endtask

    task automatic check(input bit good, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expectation per clock, sampling after the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && sb_q.size() > 0) begin
            expect_t e;
            e = sb_q.pop_front();
            check(cmp_ok == e.ok, e.tag, "cmp_ok", 64'(cmp_ok), 64'(e.ok));
            check(err_new == e.nw, e.tag, "err_new", 64'(err_new), 64'(e.nw));
            check(err_known == e.kn, e.tag, "err_known", 64'(err_known), 64'(e.kn));
            check(fault_vec == e.fv, e.tag, "fault_vec", 64'(fault_vec), 64'(e.fv));
            if (e.nw || e.kn) begin
                check(err_opcode == e.opc, e.tag, "err_opcode", 64'(err_opcode), 64'(e.opc));
                check(err_unit == e.unit, e.tag, "err_unit", 64'(err_unit), 64'(e.unit));
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model_ref[i] = '0;
        model_fv = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(fault_vec == '0, "R1", "fault_vec", 64'(fault_vec), 64'd0);
        check({cmp_ok, err_new, err_known} == 3'b000, "R1", "reports",
              64'({cmp_ok, err_new, err_known}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: unwritten slot reads zero
        drive(1, 4'd1, 32'h0, 1, 3'd6, 3'd1, 0, '0, 0, '0, '0, "R1");
        // R2 store, R6 persists across idle cycles, R3 match
        drive(1, 4'd2, 32'hA5A5_0001, 0, 3'd0, 3'd5, 0, '0, 0, '0, '0, "R2");
        idle(3, "R6");
        drive(1, 4'd2, 32'hA5A5_0001, 1, 3'd0, 3'd5, 0, '0, 0, '0, '0, "R3");
        // R4 first-time mismatch
        drive(1, 4'd3, 32'h0000_1111, 0, 3'd1, 3'd4, 0, '0, 0, '0, '0, "R2");
        drive(1, 4'd3, 32'h0000_1112, 1, 3'd1, 3'd4, 0, '0, 0, '0, '0, "R4");
        // R9 strobe then R5 known mismatch
        drive(0, '0, '0, 0, '0, '0, 1, 4'd3, 0, '0, '0, "R9");
        drive(1, 4'd3, 32'h0000_0BAD, 1, 3'd1, 3'd6, 0, '0, 0, '0, '0, "R5");
        // R9 strobe in same cycle as mismatch: still classified new
        drive(1, 4'd5, 32'hDEAD_0000, 1, 3'd1, 3'd2, 1, 4'd5, 0, '0, '0, "R9");
        drive(1, 4'd5, 32'hDEAD_0001, 1, 3'd1, 3'd2, 0, '0, 0, '0, '0, "R5");
        // R7 partner write with same-cycle compare
        drive(1, 4'd7, 32'h7777_0007, 1, 3'd2, 3'd3, 0, '0, 1, 3'd2, 32'h7777_0007, "R7");
        drive(1, 4'd7, 32'h7777_0007, 1, 3'd2, 3'd3, 0, '0, 0, '0, '0, "R7");
        // R8 own store beats partner write
        drive(1, 4'd4, 32'h4444_0004, 0, 3'd3, 3'd0, 0, '0, 1, 3'd3, 32'h9999_0009, "R8");
        drive(1, 4'd4, 32'h4444_0004, 1, 3'd3, 3'd0, 0, '0, 0, '0, '0, "R8");
        // R10 ignored slots with op_valid low
        drive(0, 4'd2, 32'hFFFF_FFFF, 0, 3'd0, 3'd1, 0, '0, 0, '0, '0, "R10");
        drive(0, 4'd6, 32'h1234_5678, 1, 3'd0, 3'd1, 0, '0, 0, '0, '0, "R10");
        drive(1, 4'd2, 32'hA5A5_0001, 1, 3'd0, 3'd5, 0, '0, 0, '0, '0, "R10");
        // R6 many stores then compares in reverse order, far apart
        for (int i = 4; i < DEPTH; i++)
            drive(1, 4'(i), 32'hC0DE_0000 + 32'(i), 0, IDX_W'(i), 3'd1, 0, '0, 0, '0, '0, "R6");
        idle(5, "R6");
        for (int i = DEPTH - 1; i >= 4; i--)
            drive(1, 4'(i), 32'hC0DE_0000 + 32'(i), 1, IDX_W'(i), 3'd1, 0, '0, 0, '0, '0, "R6");
        drive(1, 4'd6, 32'h0, 1, 3'd6, 3'd7, 0, '0, 0, '0, '0, "R4");
        idle(3, "R9");
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule